// File: doc/BRIEF.md
# Carry-free signed-digit adder/subtractor

This block adds or subtracts two N-digit numbers held in radix-2 balanced signed-digit form, where every digit is −1, 0 or +1. Each digit travels as a pair of bits, one in a "plus" word and one in a "minus" word at the same index. The value of an operand is therefore its plus word minus its minus word. This needs twice the storage of a plain binary number, and in return no carry has to travel along the operand.

The block is purely combinational. Each output digit depends on the input digits at its own position and at the two positions below it, so the delay does not grow with N. Subtraction exchanges the plus and minus words of the second operand before the addition, and involves no two's-complement step.

The addition works in two stages. At each position, the first stage splits the digit-pair sum into an interim digit and a transfer into the next position up, guided by the sign of the digit-pair sum one position below. The second stage adds each interim digit to the transfer coming in from below. The result has N+1 digits, so the top transfer is always kept.

Top module: `rsd_adder`

## Requirements
- R1: Digit i of an operand or of the result is carried by bit i of its plus word and bit i of its minus word. Plus=0/minus=0 is 0, plus=1/minus=0 is +1, and plus=0/minus=1 is −1. A number's value is the sum of digit_i·2^i.
- R2: An input digit with both bits set is taken as 0.
- R3: With `sub`=0, the N+1-digit result equals A+B exactly, for every operand pair.
- R4: With `sub`=1, the N+1-digit result equals A−B exactly. This is obtained by exchanging B's plus and minus bits.
- R5: No result digit ever has both its plus and minus bits set.
- R6: Adding an interim digit to its incoming transfer never leaves the range −1..+1. The transfer into a position is never negative when the digit-pair sum one position below is non-negative, and never positive when that sum is negative.
- R7: Changing input digit k changes no result digit below k and no result digit above k+2.
- R8: The most significant result digit (index N) holds the transfer out of position N−1. The full range, from −2·(2^N−1) to +2·(2^N−1), is represented without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_pos | input | N | plus bits of operand A |
| a_neg | input | N | minus bits of operand A |
| b_pos | input | N | plus bits of operand B |
| b_neg | input | N | minus bits of operand B |
| sub | input | 1 | 1 selects A−B, 0 selects A+B |
| sum_pos | output | N+1 | plus bits of the result |
| sum_neg | output | N+1 | minus bits of the result |

## Verification
The bench uses the default N=16. At that size every operand and result decodes into a 64-bit integer, so the result can be compared exactly against plain integer addition and subtraction. Random raw bit pairs give each digit the both-bits-set code about a quarter of the time, which exercises the rule that this code reads as zero alongside ordinary traffic. Directed all-+1 and all-−1 operands drive the top digit to both extremes, and single-digit perturbations at every position check that a change reaches only three result digits.

// File: rtl/rsd_adder.sv
module rsd_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_pos,
  input  logic [N-1:0] a_neg,
  input  logic [N-1:0] b_pos,
  input  logic [N-1:0] b_neg,
  input  logic         sub,
  output logic [N:0]   sum_pos,
  output logic [N:0]   sum_neg
);

  localparam int XW = 2 * (N + 1);

  logic [N-1:0] bp_eff, bn_eff;
  logic [N-1:0] pair_neg;
  logic [XW-1:0] xf;

  assign bp_eff = sub ? b_neg : b_pos;
  assign bn_eff = sub ? b_pos : b_neg;

  assign xf[1:0] = 2'b00;

  for (genvar i = 0; i < N; i++) begin : g_slice
    logic [2:0] da, db, p;
    logic       low_neg;
    logic [1:0] t, w, tin;
    logic [2:0] s3;

    assign da = {2'b00, a_pos[i]} - {2'b00, a_neg[i]};
    assign db = {2'b00, bp_eff[i]} - {2'b00, bn_eff[i]};
    assign p  = da + db;
    assign pair_neg[i] = p[2];

    if (i == 0) begin : g_lsd
      assign low_neg = 1'b0;
    end else begin : g_upper
      assign low_neg = pair_neg[i-1];
    end

    always_comb begin
      case (p)
        3'b010:  begin t = 2'b01; w = 2'b00; end
        3'b110:  begin t = 2'b11; w = 2'b00; end
        3'b001:  begin
          if (low_neg) begin t = 2'b00; w = 2'b01; end
          else         begin t = 2'b01; w = 2'b11; end
        end
        3'b111:  begin
          if (low_neg) begin t = 2'b11; w = 2'b01; end
          else         begin t = 2'b00; w = 2'b11; end
        end
        default: begin t = 2'b00; w = 2'b00; end
      endcase
    end

    assign xf[2*(i+1) +: 2] = t;
    assign tin = xf[2*i +: 2];
    assign s3  = {w[1], w} + {tin[1], tin};

    assign sum_pos[i] = (s3 == 3'b001);
    assign sum_neg[i] = (s3 == 3'b111);

    always_comb begin
      // R6
      no_overflow_chk: assert (s3 == 3'b000 || s3 == 3'b001 || s3 == 3'b111);
      // R3
      slice_value_chk: assert (3'({t, 1'b0} + {w[1], w}) == p);
      // R6
      xfer_sign_chk: assert (low_neg ? (tin != 2'b01) : (tin != 2'b11));
    end
  end

  assign sum_pos[N] = (xf[XW-2 +: 2] == 2'b01);
  assign sum_neg[N] = (xf[XW-2 +: 2] == 2'b11);

  always_comb begin
    // R5
    code_chk: assert ((sum_pos & sum_neg) == '0);
  end

endmodule

// File: tb/test_rsd_adder.sv
module test_rsd_adder;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] a_pos, a_neg, b_pos, b_neg;
  logic         sub;
  logic [N:0]   sum_pos, sum_neg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rsd_adder #(.N(N)) i_rsd_adder (
    .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
    .sub(sub), .sum_pos(sum_pos), .sum_neg(sum_neg)
  );

  function automatic longint dec_in(input logic [N-1:0] p, input logic [N-1:0] n);
    longint v = 0;
    for (int i = 0; i < N; i++) v += (longint'(p[i]) - longint'(n[i])) <<< i;
    return v;
  endfunction

  function automatic longint dec_out(input logic [N:0] p, input logic [N:0] n);
    longint v = 0;
    for (int i = 0; i <= N; i++) v += (longint'(p[i]) - longint'(n[i])) <<< i;
    return v;
  endfunction

  task automatic check_val(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] ap, input logic [N-1:0] an,
                       input logic [N-1:0] bp, input logic [N-1:0] bn, input logic s);
    @(negedge clk);
    a_pos = ap; a_neg = an; b_pos = bp; b_neg = bn; sub = s;
    #1;
  endtask

  task automatic check_result(input string req);
    longint exp;
    exp = sub ? dec_in(a_pos, a_neg) - dec_in(b_pos, b_neg)
              : dec_in(a_pos, a_neg) + dec_in(b_pos, b_neg);
    check_val(req, dec_out(sum_pos, sum_neg), exp);
    // R5: no digit uses the both-bits-set code
    check_val("R5", longint'(sum_pos & sum_neg), 0);
  endtask

  localparam logic [N-1:0] ONES = '1;

  initial begin
    logic [N:0] ref_p, ref_n;
    void'($urandom(32'd20240611));
    a_pos = '0; a_neg = '0; b_pos = '0; b_neg = '0; sub = 1'b0;
    #1;
    // R1: all-zero operands give the zero code everywhere
    check_val("R1", longint'(sum_pos), 0);
    check_val("R1", longint'(sum_neg), 0);

    // R1: single digits of each code
    apply(16'h0001, 16'h0000, 16'h0000, 16'h0002, 1'b0);
    check_result("R1");
    // R8: top digit at both extremes
    apply(ONES, '0, ONES, '0, 1'b0);
    check_result("R8");
    check_val("R8", dec_out(sum_pos, sum_neg), 2 * ((longint'(1) <<< N) - 1));
    apply('0, ONES, '0, ONES, 1'b0);
    check_result("R8");
    check_val("R8", longint'(sum_neg[N]), 1);
    apply(ONES, '0, '0, ONES, 1'b1);
    check_result("R8");
    apply(16'h5555, 16'hAAAA, 16'hAAAA, 16'h5555, 1'b0);
    check_result("R3");
    // R2: operand A entirely both-bits-set reads as zero
    apply(ONES, ONES, 16'h1234, 16'h0C01, 1'b0);
    check_val("R2", dec_out(sum_pos, sum_neg), dec_in(16'h1234, 16'h0C01));
    apply(ONES, ONES, 16'h1234, 16'h0C01, 1'b1);
    check_val("R2", dec_out(sum_pos, sum_neg), -dec_in(16'h1234, 16'h0C01));
    apply(16'h00F0, 16'h0000, ONES, ONES, 1'b1);
    check_val("R2", dec_out(sum_pos, sum_neg), 240);
    // R4: A - A is zero
    apply(16'h3C5A, 16'h8101, 16'h3C5A, 16'h8101, 1'b1);
    check_val("R4", dec_out(sum_pos, sum_neg), 0);

    // R3 / R4: random raw patterns, about a quarter of digits coded both-bits-set
    for (int k = 0; k < 600; k++) begin
      apply(N'($urandom), N'($urandom), N'($urandom), N'($urandom), 1'(k & 1));
      check_result((k & 1) ? "R4" : "R3");
    end

    // R7: a change at digit j touches only result digits j..j+2
    for (int j = 0; j < N; j++) begin
      logic [N-1:0] ap, an, bp, bn;
      logic [N:0] mask;
      ap = N'($urandom); an = N'($urandom) & ~ap;
      bp = N'($urandom); bn = N'($urandom) & ~bp;
      apply(ap, an, bp, bn, 1'b0);
      ref_p = sum_pos; ref_n = sum_neg;
      if (ap[j]) begin ap[j] = 1'b0; an[j] = 1'b1; end
      else if (an[j]) begin an[j] = 1'b0; end
      else begin ap[j] = 1'b1; end
      apply(ap, an, bp, bn, 1'b0);
      check_result("R7");
      mask = '1;
      for (int q = j; q <= j + 2 && q <= N; q++) mask[q] = 1'b0;
      check_val("R7", longint'((sum_pos ^ ref_p) & mask), 0);
      check_val("R7", longint'((sum_neg ^ ref_n) & mask), 0);
    end

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule